// File: doc/BRIEF.md
# Wait-State Register Completer

This block is a peripheral on the APB bus that holds a small bank of 32-bit registers. Each access stalls for a number of Access cycles that an input sets, which models a slow fetch behind the bus. While the transfer is stalled, ready stays low. Ready goes high for exactly one cycle to end the transfer.

Read data leaves the block only in the cycle that completes a read. In every other cycle the read data output is zero: while the block is not selected, during the Setup phase, during wait states and throughout writes. Because of this, several such peripherals can share one read bus through a plain OR.

Writes take effect at the completion edge, and byte strobes gate each lane. An address past the last register finishes with an error flag. Such a write changes nothing, and such a read returns zero.

Top module: `slow_reg_completer`

## Requirements
- R1: With `wait_cfg` = N (0 to 15, held stable during a transfer), `pready` is low in the first N Access cycles and high in Access cycle N+1. `pready` is low outside the Access phase.
- R2: With `wait_cfg` = 0, `pready` is high in the first Access cycle, so a transfer takes two cycles (Setup and one Access).
- R3: While `psel` is 0, `prdata` is zero.
- R4: `prdata` is zero in the Setup phase, in every wait-state cycle and throughout write transfers. Register contents appear only in the completion cycle of a read.
- R5: A read of an in-range address returns the addressed register word. The register index is `paddr[ADDR_W-1:2]`, the low two address bits are ignored, and there are NREG registers.
- R6: A write changes byte lane k (bits 8k+7:8k) of the addressed register only when `pstrb[k]` is 1. The change takes effect at the completion edge. Lanes whose strobe is 0 keep their value.
- R7: An address whose index is NREG or more completes with `pslverr` = 1. A write to such an address changes no register, and a read of it returns zero.
- R8: `pslverr` is 0 in every cycle that is not a completion cycle.
- R9: The wait counter restarts for each Access phase. Back-to-back transfers, with `psel` held high, each see the full N wait states.
- R10: After reset, every register reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data |
| pstrb | input | DATA_W/8 | Byte-lane write strobes |
| wait_cfg | input | WAIT_W | Number of wait states per access |
| prdata | output | DATA_W | Read data, zero outside a read completion |
| pready | output | 1 | Transfer completes in this cycle |
| pslverr | output | 1 | Address error, meaningful at completion |

## Verification
A wait counter that drifts by one shows up at the very next transfer as a `pready` that rises one cycle early or late. The bench catches this because it checks `pready` in every Access cycle for each of the sixteen wait counts. A corrupted register lane, or a stray write from an out-of-range address or from a zero strobe, stays hidden until that register is next read. For that reason, every write sweep is followed by a read-back of all registers, compared against a shadow model built from the strobes. Any leak of register contents onto `prdata` outside a read completion is visible in the same cycle, because `prdata` is checked for zero in every Setup, wait and idle cycle.

// File: rtl/slow_reg_completer.sv
module slow_reg_completer #(
  parameter int DATA_W = 32,
  parameter int NREG   = 4,
  parameter int ADDR_W = 8,
  parameter int WAIT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                psel,
  input  logic                penable,
  input  logic                pwrite,
  input  logic [ADDR_W-1:0]   paddr,
  input  logic [DATA_W-1:0]   pwdata,
  input  logic [DATA_W/8-1:0] pstrb,
  input  logic [WAIT_W-1:0]   wait_cfg,
  output logic [DATA_W-1:0]   prdata,
  output logic                pready,
  output logic                pslverr
);
  localparam int STRB_W = DATA_W / 8;
  localparam int IDX_W  = ADDR_W - 2;
  localparam logic [IDX_W:0] NREG_L = NREG[IDX_W:0];

  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [WAIT_W-1:0]           cnt;
  logic [DATA_W-1:0]           rword;

  wire             access = psel & penable;
  wire [IDX_W-1:0] idx    = paddr[ADDR_W-1:2];
  wire             hit    = {1'b0, idx} < NREG_L;
  wire             done   = access & (cnt == wait_cfg);

  assign pready  = done;
  assign pslverr = done & ~hit;
  assign prdata  = (done & ~pwrite & hit) ? rword : '0;

  always_comb begin
    rword = '0;
    for (int i = 0; i < NREG; i++)
      if ({1'b0, idx} == i[IDX_W:0]) rword = regs[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (access & ~done)  cnt <= cnt + 1'b1;
    else                      cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '0;
    else if (done & pwrite & hit)
      for (int i = 0; i < NREG; i++)
        for (int b = 0; b < STRB_W; b++)
          if ({1'b0, idx} == i[IDX_W:0] && pstrb[b])
            regs[i][b*8 +: 8] <= pwdata[b*8 +: 8];
  end

  p_no_early_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(penable) && psel && wait_cfg != '0) |-> !pready);
  p_ready_outside_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable) |-> !pready);
  p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(penable) && psel && wait_cfg == '0) |-> pready);
  p_idle_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !psel |-> prdata == '0);
  p_wait_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pready || pwrite) |-> prdata == '0);
  p_nostrobe_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pready && pwrite && pstrb == '0) |=> $stable(regs));
  p_oob_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pslverr && pwrite) |=> $stable(regs));
  p_err_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pslverr |-> (psel && penable && pready));
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pready |=> cnt == '0);
endmodule

// File: tb/slow_reg_completer_tb.sv
module slow_reg_completer_tb;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 32;
  localparam int NREG   = 4;
  localparam int ADDR_W = 8;
  localparam int WAIT_W = 4;
  localparam int STRB_W = DATA_W / 8;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [DATA_W-1:0] pwdata = '0;
  logic [STRB_W-1:0] pstrb = '0;
  logic [WAIT_W-1:0] wait_cfg = '0;
  logic [DATA_W-1:0] prdata;
  logic pready, pslverr;

  int tests = 0, fails = 0;
  logic [DATA_W-1:0] shadow [NREG];

  always #(CLK_P/2) clk = ~clk;

  slow_reg_completer #(.DATA_W(DATA_W), .NREG(NREG), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .wait_cfg(wait_cfg),
    .prdata(prdata), .pready(pready), .pslverr(pslverr));

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    psel = 0; penable = 0;
    #1;
    chk("R3 idle prdata", prdata, '0);
    chk("R1 idle pready", {31'b0, pready}, 0);
    chk("R8 idle pslverr", {31'b0, pslverr}, 0);
  endtask

  task automatic xfer(input logic wr, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, input logic [STRB_W-1:0] s,
                      input int n);
    int idx = int'(a[ADDR_W-1:2]);
    logic inr = idx < NREG;
    logic [DATA_W-1:0] exp_rd = (!wr && inr) ? shadow[idx] : '0;
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
    wait_cfg = WAIT_W'(n);
    #1;
    chk("R1 setup pready", {31'b0, pready}, 0);
    chk("R4 setup prdata", prdata, '0);
    chk("R8 setup pslverr", {31'b0, pslverr}, 0);
    @(negedge clk);
    penable = 1;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) @(negedge clk);
      #1;
      chk(n == 0 ? "R2 pready" : "R1/R9 pready", {31'b0, pready}, {31'b0, k == n});
      chk(k == n ? "R5/R7 prdata" : "R4 wait prdata", prdata, k == n ? exp_rd : '0);
      chk(k == n ? "R7 pslverr" : "R8 pslverr", {31'b0, pslverr}, {31'b0, (k == n) && !inr});
    end
    if (wr && inr)
      for (int b = 0; b < STRB_W; b++)
        if (s[b]) shadow[idx][b*8 +: 8] = d[b*8 +: 8];
  endtask

  task automatic read_all(input int n);
    for (int r = 0; r < NREG; r++) xfer(0, ADDR_W'(r * 4 + (r % 4)), '0, '0, n);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int r = 0; r < NREG; r++) shadow[r] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R3 reset prdata", prdata, '0);
    chk("R1 reset pready", {31'b0, pready}, 0);
    rst_n = 1;
    // R10: registers start at zero
    read_all(0);
    idle_cycle();
    // R1 R2 R5 R6 R9: every wait count, back-to-back writes then reads
    for (int n = 0; n < 16; n++) begin
      for (int r = 0; r < NREG; r++)
        xfer(1, ADDR_W'(r * 4), 32'h1000_0000 * n + 32'h0101_0101 * (r + 1) + n,
             STRB_W'((n + r) % 16), n);
      read_all(n);
      if (n % 3 == 0) idle_cycle();
    end
    // R6: every strobe pattern on one register
    for (int s = 0; s < 16; s++) begin
      xfer(1, 8'h04, 32'hA5C3_0000 ^ (32'h1111_1111 * s), STRB_W'(s), 1);
      xfer(0, 8'h04, '0, '0, 1);
    end
    idle_cycle();
    // R7: every out-of-range index, write then read, registers untouched
    for (int i = NREG; i < (1 << (ADDR_W - 2)); i++) begin
      xfer(1, ADDR_W'(i * 4), 32'hFFFF_FFFF, 4'hF, i % 3);
      xfer(0, ADDR_W'(i * 4), '0, '0, i % 2);
    end
    read_all(2);
    idle_cycle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule